// File: doc/BRIEF.md
# I2C Pad General-Purpose Output Controller

This block drives the two I2C pads, the data line and the clock line, when they are used as plain general-purpose pins instead of by a protocol engine. It holds one output bit per pad. Software can change those bits in three ways. It can load both bits at once, set chosen bits by writing ones, or clear chosen bits by writing ones. A separate mode register selects, for each pad, whether a high level is driven actively or left floating.

Each pad gets a registered driver pair, a value and an output enable, for the pad ring. In floating-high (open-drain) mode the driven value is always 0, and the enable is asserted only while the pad's bit is 0. In actively-driven (push-pull) mode the enable is always asserted and the driven value follows the bit.

Register access uses a plain 16-bit bus with an address, a write strobe, write data and combinational read data. It is a control path with no streamed data, so it has no valid/ready handshake. A write is accepted on every clock edge where the strobe is high. In every register, bit 1 is the data pad and bit 0 is the clock pad.

Top module: `i2c_pin_gpio_ctl`

## Requirements
- R1: After reset, both output bits and both mode bits are 0. Every register reads 0, and both pads have enable 1 and value 0.
- R2: A write to byte offset 0x54 loads bits [1:0] into the output bits. A read of 0x54 returns them.
- R3: A write to offset 0x58 sets each output bit whose write-data bit is 1 and leaves the other output bits unchanged. A read of 0x58 returns the output bits.
- R4: A write to offset 0x5C clears each output bit whose write-data bit is 1 and leaves the other output bits unchanged. A read of 0x5C returns the output bits.
- R5: Offset 0x60 holds the mode bits: 0 selects open-drain and 1 selects push-pull. The mode bits are written and read back at this offset.
- R6: In open-drain mode a pad has value 0 at all times. Its enable is 1 while its output bit is 0 and 0 while its output bit is 1.
- R7: In push-pull mode a pad's enable is 1 and its value equals its output bit.
- R8: Bits 15:2 of every register read as 0, and writes to those bits have no effect.
- R9: Reads of any other offset return 0, and writes to any other offset change no state.
- R10: Output bits and mode bits update on the clock edge that samples the write. The pad pair reflects the new state on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| pad_out | output | 2 | Pad drive values, bit 1 data, bit 0 clock |
| pad_oe | output | 2 | Pad output enables, bit 1 data, bit 0 clock |

## Verification
The assertions assume that the address and the write strobe are stable around each clock edge and are never unknown once reset is released. They make no assumption about the write-data value, so any pattern of ones and zeros is legal. The directed stimulus changes inputs only at falling edges and drops the strobe after a single cycle, so each write is sampled exactly once. Write data deliberately carries ones in bits 15:2 to show that those bits are ignored.

// File: rtl/i2c_pin_gpio_pkg.sv
package i2c_pin_gpio_pkg;
  localparam int unsigned PIN_CLK = 0;
  localparam int unsigned PIN_DAT = 1;
  localparam int unsigned NUM_PAD = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD,
    SEL_SET,
    SEL_CLEAR,
    SEL_MODE
  } reg_sel_e;
endpackage

// File: rtl/i2c_pin_gpio_regs.sv
module i2c_pin_gpio_regs
  import i2c_pin_gpio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NPINS    = NUM_PAD,
  parameter logic [ADDR_W-1:0] OFS_LOAD  = 'h54,
  parameter logic [ADDR_W-1:0] OFS_SET   = 'h58,
  parameter logic [ADDR_W-1:0] OFS_CLEAR = 'h5C,
  parameter logic [ADDR_W-1:0] OFS_MODE  = 'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [NPINS-1:0]  wbits,
  output logic [NPINS-1:0]  level_q,
  output logic [NPINS-1:0]  drive_q,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;

  always_comb begin
    if (addr == OFS_LOAD)       sel = SEL_LOAD;
    else if (addr == OFS_SET)   sel = SEL_SET;
    else if (addr == OFS_CLEAR) sel = SEL_CLEAR;
    else if (addr == OFS_MODE)  sel = SEL_MODE;
    else                        sel = SEL_NONE;
  end

  logic [NPINS-1:0] level_d;
  always_comb begin
    level_d = level_q;
    if (wr) begin
      unique case (sel)
        SEL_LOAD:  level_d = wbits;
        SEL_SET:   level_d = level_q | wbits;
        SEL_CLEAR: level_d = level_q & ~wbits;
        default:   level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      drive_q <= '0;
    end else begin
      level_q <= level_d;
      if (wr && sel == SEL_MODE) drive_q <= wbits;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LOAD, SEL_SET, SEL_CLEAR: rdata = DATA_W'(level_q);
      SEL_MODE:                     rdata = DATA_W'(drive_q);
      default:                      rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_pin_gpio_pad.sv
module i2c_pin_gpio_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic push_pull,
  output logic drv_val,
  output logic drv_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_val <= 1'b0;
      drv_en  <= 1'b1;
    end else begin
      drv_val <= push_pull & level;
      drv_en  <= push_pull | ~level;
    end
  end
endmodule

// File: rtl/i2c_pin_gpio_ctl.sv
module i2c_pin_gpio_ctl
  import i2c_pin_gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_PAD-1:0] pad_out,
  output logic [NUM_PAD-1:0] pad_oe
);
  logic [NUM_PAD-1:0] level_q;
  logic [NUM_PAD-1:0] drive_q;
  logic               unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:NUM_PAD];

  i2c_pin_gpio_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPINS(NUM_PAD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wbits(bus_wdata[NUM_PAD-1:0]), .level_q(level_q),
    .drive_q(drive_q), .rdata(bus_rdata)
  );

  for (genvar p = 0; p < NUM_PAD; p++) begin : g_pad
    i2c_pin_gpio_pad u_pad (
      .clk(clk), .rst_n(rst_n), .level(level_q[p]),
      .push_pull(drive_q[p]), .drv_val(pad_out[p]), .drv_en(pad_oe[p])
    );
  end
endmodule

// File: rtl/i2c_pin_gpio_chk.sv
module i2c_pin_gpio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic       wr,
  input logic [1:0] wbits,
  input logic [15:0] rdata,
  input logic [1:0] level_q,
  input logic [1:0] drive_q,
  input logic [1:0] pad_out,
  input logic [1:0] pad_oe
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 8'h54) |=> level_q == $past(wbits)); // R2
  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 8'h58) |=> level_q == ($past(level_q) | $past(wbits))); // R3
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 8'h5C) |=> level_q == ($past(level_q) & ~$past(wbits))); // R4
  AST_MODE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 8'h60) |=> drive_q == $past(wbits)); // R5
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pad_oe & $past(~drive_q & level_q)) == 2'b00); // R6
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pad_out & $past(~drive_q)) == 2'b00); // R6
  AST_PP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pad_out ^ $past(level_q)) & $past(drive_q)) == 2'b00); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:2] == 14'd0); // R8
  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != 8'h54 && addr != 8'h58 && addr != 8'h5C && addr != 8'h60)
    |=> $stable(level_q) && $stable(drive_q)); // R9
endmodule

bind i2c_pin_gpio_ctl i2c_pin_gpio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
  .wbits(bus_wdata[1:0]), .rdata(bus_rdata), .level_q(level_q),
  .drive_q(drive_q), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/i2c_pin_gpio_ctl_tb.sv
module i2c_pin_gpio_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  pad_out, pad_oe;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] m_lvl = 2'b00;
  logic [1:0] m_pp  = 2'b00;

  always #10 clk = ~clk;

  i2c_pin_gpio_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pad_check(input string req);
    @(negedge clk);
    check({req, " oe"}, {14'd0, pad_oe}, {14'd0, m_pp | ~m_lvl});
    check({req, " out"}, {14'd0, pad_out}, {14'd0, m_pp & m_lvl});
  endtask

  task automatic t_reset;
    read_check("R1 load", 8'h54, 16'h0);
    read_check("R1 mode", 8'h60, 16'h0);
    check("R1 oe", {14'd0, pad_oe}, 16'h3);
    check("R1 out", {14'd0, pad_out}, 16'h0);
  endtask

  task automatic t_load;
    bus_write(8'h54, 16'hFFFE); m_lvl = 2'b10;
    read_check("R2", 8'h54, 16'h2);
    read_check("R8 upper", 8'h54, 16'h2);
    check("R10 not yet", {14'd0, pad_oe}, 16'h3);
    pad_check("R10 R6 od");
  endtask

  task automatic t_set;
    bus_write(8'h58, 16'h0001); m_lvl = 2'b11;
    read_check("R3", 8'h58, 16'h3);
    bus_write(8'h58, 16'h0000);
    read_check("R3 zero", 8'h58, 16'h3);
    pad_check("R6 release");
  endtask

  task automatic t_clear;
    bus_write(8'h5C, 16'h0002); m_lvl = 2'b01;
    read_check("R4", 8'h5C, 16'h1);
    bus_write(8'h5C, 16'h0000);
    read_check("R4 zero", 8'h5C, 16'h1);
    pad_check("R6 mix");
  endtask

  task automatic t_mode;
    bus_write(8'h60, 16'hFFFD); m_pp = 2'b01;
    read_check("R5", 8'h60, 16'h1);
    pad_check("R7 clk pp");
    bus_write(8'h60, 16'h0003); m_pp = 2'b11;
    read_check("R5 both", 8'h60, 16'h3);
    pad_check("R7 both");
    bus_write(8'h54, 16'h0000); m_lvl = 2'b00;
    pad_check("R7 low");
  endtask

  task automatic t_unmapped;
    bus_write(8'h50, 16'hFFFF);
    bus_write(8'h64, 16'hFFFF);
    read_check("R9 read", 8'h50, 16'h0);
    read_check("R9 load", 8'h54, 16'h0);
    read_check("R9 mode", 8'h60, 16'h3);
    pad_check("R9 pads");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load();
        t_set();
        t_clear();
        t_mode();
        t_unmapped();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule